// File: doc/BRIEF.md
# Interrupt-Capable Parallel I/O Bank

This block is one bank of thirty-two general-purpose pins behind a small memory-mapped register port. Software sets output values and per-pin drive enables, and it reads back input levels that first pass through a two-stage synchroniser. Each pin can also raise an interrupt. A per-pin routing bit turns detection on for that pin. Two more bits pick between edge and level sensing and choose the active polarity. Detected events collect in sticky status bits. The status bits are masked by an enable register and combined into one interrupt line for the whole bank.

Every register can be reached at three addresses. The plain address replaces the whole word. The set address ORs the written ones into the register. The clear address removes the written ones from it. A driver can therefore change one pin's configuration without a read-modify-write sequence. Status bits are acknowledged only through the clear address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is all zeros and `irq_out` is low.
- R2: Address bits [6:4] select the register: 0 output value, 1 input value, 2 drive enable, 3 interrupt routing, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Bits [3:2] select the access kind: 0 replaces the word, 1 ORs in the write data, 2 clears the bits that are 1 in the write data, 3 leaves the register unchanged.
- R3: A read at any of the four access kinds of a register returns that register's current value.
- R4: The input register reads the pin levels after two flip-flops. A level applied before one rising edge is not yet visible, and it is visible after the second rising edge. Writes to the input register have no effect.
- R5: `pin_oe` equals the drive-enable register. `pin_out` carries the output-value bit where that pin is enabled and 0 where it is not.
- R6: The mode of a pin is {polarity, level}. Code 00 is falling edge and code 10 is rising edge. In an edge mode, a change of the synchronised input to the active value sets that pin's status bit once. A steady input sets nothing.
- R7: Code 01 is low level and code 11 is high level. In a level mode, the status bit is set on every cycle that the synchronised input is at the active value. When a clear and a set of the same bit fall in the same cycle, the bit stays set.
- R8: Status bits are sticky. Only a write at the clear address (access kind 2) of register 7 resets them. Plain and set writes to status do not change it.
- R9: A pin whose routing bit is 0 never sets its status bit.
- R10: `irq_out` is high exactly when some bit is set in both the status and the interrupt-enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register select [6:4] and access kind [3:2] |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw asynchronous pin levels |
| pin_out | output | 32 | Output values, zero where not driven |
| pin_oe | output | 32 | Per-pin drive enable |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
The synchroniser check takes for granted that reset is held for at least two clock cycles, so that both flop stages hold known values once reset ends. The status checks take for granted that detection runs only on synchronised data, so a raw pin may change at any time. The stimulus holds reset for several cycles and changes pins and bus signals only on the falling clock edge. It also waits several cycles after each pin change, so the two synchroniser stages and the edge-history flop have settled before status is read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        RG_DOUT = 3'd0,
        RG_DIN  = 3'd1,
        RG_OE   = 3'd2,
        RG_SEL  = 3'd3,
        RG_EN   = 3'd4,
        RG_LEV  = 3'd5,
        RG_POL  = 3'd6,
        RG_STAT = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        AC_WRITE = 2'd0,
        AC_SET   = 2'd1,
        AC_CLR   = 2'd2,
        AC_NONE  = 2'd3
    } access_e;

    typedef struct packed {
        logic     wr;
        reg_idx_e idx;
        access_e  acc;
    } bus_cmd_t;

    localparam int REG_COUNT = 8;

    function automatic bus_cmd_t decode_cmd(input logic [6:0] addr, input logic wr);
        bus_cmd_t c;
        c.wr  = wr;
        c.idx = reg_idx_e'(addr[6:4]);
        c.acc = access_e'(addr[3:2]);
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // R4: the last stage follows the stage before it by one cycle
    p_sync_chain_r4: assert property (@(posedge clk) disable iff (rst)
        sync_out == $past(stage_q[STAGES-2]));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] route,
    input  logic [W-1:0] lvl_mode,
    input  logic [W-1:0] polarity,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic at_active;
        logic changed;
        assign at_active = ~(level_in[i] ^ polarity[i]);
        assign changed   = level_in[i] ^ prev_q[i];
        assign hit[i]    = route[i] & at_active & (lvl_mode[i] | changed);
    end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_cmd_t     cmd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] synced,
    input  logic [W-1:0] hit,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe,
    output logic [W-1:0] route,
    output logic [W-1:0] irq_en,
    output logic [W-1:0] lvl_mode,
    output logic [W-1:0] polarity,
    output logic [W-1:0] status
);
    logic [W-1:0] reg_val [REG_COUNT];

    function automatic logic [W-1:0] apply_access(input logic [W-1:0] cur,
                                                 input logic [W-1:0] d,
                                                 input access_e acc);
        case (acc)
            AC_WRITE: return d;
            AC_SET:   return cur | d;
            AC_CLR:   return cur & ~d;
            default:  return cur;
        endcase
    endfunction

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        if (g == int'(RG_DIN)) begin : g_in
            assign reg_val[g] = synced;
        end else if (g == int'(RG_STAT)) begin : g_stat
            logic [W-1:0] stat_q;
            logic [W-1:0] ack;
            assign ack = (cmd.wr && cmd.idx == RG_STAT && cmd.acc == AC_CLR) ? wdata : '0;
            always_ff @(posedge clk) begin
                if (rst) stat_q <= '0;
                else     stat_q <= (stat_q & ~ack) | hit;
            end
            assign reg_val[g] = stat_q;
        end else begin : g_cfg
            logic [W-1:0] cfg_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cfg_q <= '0;
                else if (cmd.wr && cmd.idx == reg_idx_e'(g))
                    cfg_q <= apply_access(cfg_q, wdata, cmd.acc);
            end
            assign reg_val[g] = cfg_q;
        end
    end

    assign rdata    = reg_val[cmd.idx];
    assign dout     = reg_val[RG_DOUT];
    assign oe       = reg_val[RG_OE];
    assign route    = reg_val[RG_SEL];
    assign irq_en   = reg_val[RG_EN];
    assign lvl_mode = reg_val[RG_LEV];
    assign polarity = reg_val[RG_POL];
    assign status   = reg_val[RG_STAT];

    // R8: a status bit only falls after a clear-address write to status
    p_stat_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && cmd.idx == RG_STAT && cmd.acc == AC_CLR)
        |=> (($past(status) & ~status) == '0));

    // R7: a detection hit always leaves its status bit set, clear or not
    p_hit_sets_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(hit)) == $past(hit)));

    // R9: no status bit rises on a pin that was not routed
    p_unrouted_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(route)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_out
);
    bus_cmd_t         cmd;
    logic [NPINS-1:0] synced, hit;
    logic [NPINS-1:0] dout, oe, route, irq_en, lvl_mode, polarity, status;

    assign cmd = decode_cmd(bus_addr, bus_wr);

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .raw_in(pin_in), .sync_out(synced)
    );

    gpio_trig_detect #(.W(NPINS)) detect_i (
        .clk(clk), .rst(rst), .level_in(synced), .route(route),
        .lvl_mode(lvl_mode), .polarity(polarity), .hit(hit)
    );

    gpio_reg_file #(.W(NPINS)) regs_i (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata),
        .synced(synced), .hit(hit), .rdata(bus_rdata),
        .dout(dout), .oe(oe), .route(route), .irq_en(irq_en),
        .lvl_mode(lvl_mode), .polarity(polarity), .status(status)
    );

    assign pin_out = dout & oe;
    assign pin_oe  = oe;
    assign irq_out = |(status & irq_en);

    // R1: the cycle reset ends, nothing is driven and no interrupt is raised
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && !irq_out));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // register numbers and access kinds as stated in R2
    localparam logic [2:0] X_DOUT = 3'd0, X_DIN = 3'd1, X_OE = 3'd2, X_SEL = 3'd3,
                           X_EN = 3'd4, X_LEV = 3'd5, X_POL = 3'd6, X_STAT = 3'd7;
    localparam logic [1:0] K_WR = 2'd0, K_SET = 2'd1, K_CLR = 2'd2, K_NONE = 2'd3;
    localparam int P = 5;

    // {polarity, level, start level, end level, expected status} per R6 and R7
    localparam logic [4:0] VEC [16] = '{
        5'b00000, 5'b00010, 5'b00101, 5'b00110,
        5'b01001, 5'b01011, 5'b01101, 5'b01110,
        5'b10000, 5'b10011, 5'b10100, 5'b10110,
        5'b11000, 5'b11011, 5'b11101, 5'b11111
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [1:0] kind, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {idx, kind, 2'b00};
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [1:0] kind, output logic [31:0] d);
        bus_addr = {idx, kind, 2'b00};
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), K_WR, v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset pin_oe", pin_oe, 32'h0);
        check("R1 reset irq_out", {31'h0, irq_out}, 32'h0);

        // R2 access kinds, R3 alias reads
        wr(X_DOUT, K_WR, 32'hA5A5_0F0F);
        rd(X_DOUT, K_WR, v);  check("R2 replace write", v, 32'hA5A5_0F0F);
        wr(X_DOUT, K_SET, 32'h0000_F000);
        rd(X_DOUT, K_WR, v);  check("R2 set write", v, 32'hA5A5_FF0F);
        wr(X_DOUT, K_CLR, 32'h0000_0F0F);
        rd(X_DOUT, K_WR, v);  check("R2 clear write", v, 32'hA5A5_F000);
        wr(X_DOUT, K_NONE, 32'hFFFF_FFFF);
        rd(X_DOUT, K_WR, v);  check("R2 kind 3 no change", v, 32'hA5A5_F000);
        rd(X_DOUT, K_SET, v); check("R3 read at set address", v, 32'hA5A5_F000);
        rd(X_DOUT, K_CLR, v); check("R3 read at clear address", v, 32'hA5A5_F000);

        // R5 drive gating
        wr(X_OE, K_WR, 32'hFFFF_0000);
        check("R5 pin_out gated", pin_out, 32'hA5A5_0000);
        check("R5 pin_oe", pin_oe, 32'hFFFF_0000);

        // R4 synchroniser latency and write immunity
        @(negedge clk);
        pin_in = 32'h1234_5678;
        @(negedge clk);
        rd(X_DIN, K_WR, v);  check("R4 not visible after one edge", v, 32'h0);
        @(negedge clk);
        rd(X_DIN, K_WR, v);  check("R4 visible after two edges", v, 32'h1234_5678);
        wr(X_DIN, K_WR, 32'hFFFF_FFFF);
        rd(X_DIN, K_WR, v);  check("R4 write ignored", v, 32'h1234_5678);
        pin_in = '0;
        idle(5);

        // R9 unrouted pin with high-level mode never latches
        wr(X_LEV, K_SET, 32'h0000_0200);
        wr(X_POL, K_SET, 32'h0000_0200);
        wr(X_STAT, K_CLR, 32'hFFFF_FFFF);
        pin_in[9] = 1'b1;
        idle(6);
        rd(X_STAT, K_WR, v); check("R9 unrouted status", v, 32'h0);
        pin_in[9] = 1'b0;
        wr(X_LEV, K_WR, 32'h0);
        wr(X_POL, K_WR, 32'h0);

        // R6, R7, R10 vector walk on one routed, enabled pin
        wr(X_SEL, K_SET, 32'h1 << P);
        wr(X_EN, K_SET, 32'h1 << P);
        for (int n = 0; n < 16; n++) begin
            logic [4:0] e;
            e = VEC[n];
            @(negedge clk);
            pin_in[P] = e[2];
            idle(5);
            wr(X_LEV, e[3] ? K_SET : K_CLR, 32'h1 << P);
            wr(X_POL, e[4] ? K_SET : K_CLR, 32'h1 << P);
            idle(3);
            wr(X_STAT, K_CLR, 32'hFFFF_FFFF);
            pin_in[P] = e[1];
            idle(5);
            rd(X_STAT, K_WR, v);
            check(e[3] ? "R7 level mode status" : "R6 edge mode status", v, {31'h0, e[0]} << P);
            check("R10 irq from enabled status", {31'h0, irq_out}, {31'h0, e[0]});
        end

        // R8 sticky status: rising edge latch, then plain and set writes
        wr(X_LEV, K_CLR, 32'h1 << P);
        wr(X_POL, K_SET, 32'h1 << P);
        @(negedge clk); pin_in[P] = 1'b0;
        idle(5);
        wr(X_STAT, K_CLR, 32'hFFFF_FFFF);
        pin_in[P] = 1'b1;
        idle(5);
        wr(X_STAT, K_WR, 32'h0);
        rd(X_STAT, K_WR, v); check("R8 replace write ignored", v, 32'h1 << P);
        wr(X_STAT, K_SET, 32'hFFFF_FFFF);
        rd(X_STAT, K_WR, v); check("R8 set write ignored", v, 32'h1 << P);

        // R10 enable gating
        wr(X_EN, K_CLR, 32'h1 << P);
        check("R10 masked irq", {31'h0, irq_out}, 32'h0);
        wr(X_EN, K_SET, 32'h1 << P);
        check("R10 unmasked irq", {31'h0, irq_out}, 32'h1);

        wr(X_STAT, K_CLR, 32'h1 << P);
        rd(X_STAT, K_WR, v); check("R8 clear address clears", v, 32'h0);

        // R7 set wins over clear while high level persists
        wr(X_LEV, K_SET, 32'h1 << P);
        idle(2);
        wr(X_STAT, K_CLR, 32'h1 << P);
        rd(X_STAT, K_WR, v); check("R7 set wins over clear", v, 32'h1 << P);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule